// File: doc/BRIEF.md
# Register Move with Immediate Shift Decoder

This block is a purely combinational decoder for one instruction family: copying a register to a destination register, optionally shifted or rotated by an immediate amount. It accepts one 32-bit instruction word and a layout select, which names one of three layouts:

- the 32-bit fixed-width layout;
- the 16-bit compact layout, which has two sub-forms;
- the 32-bit wide compact layout.

It also accepts the current conditional-block status: whether the instruction sits inside a conditional block, and whether it is the last instruction of that block. From these it produces one unified micro-operation:

- destination and source register indices;
- the flag-update decision;
- the shift kind and the raw 5-bit shift amount;
- a condition code;
- a valid flag;
- a flag that marks encodings whose architectural outcome is not defined.

A pipeline decode stage places the block beside the other family decoders and uses `valid` to select its result. The block does not evaluate conditions, read registers or execute anything. A 16-bit compact instruction is presented in bits 15:0 of the word. A wide compact instruction is presented with its first halfword in bits 31:16 and its second halfword in bits 15:0.

Top module: `mvsh_decoder`

## Requirements
- R1: With `enc_mode` = 2'b00 (fixed-width), a word with bits 27:21 = 0001101 and bit 4 = 0 decodes as valid. Its fields map as follows: `set_flags` = bit 20, `dst_idx` = bits 15:12, `shift_amt` = bits 11:7, `shift_kind` = bits 6:5, `src_idx` = bits 3:0.
- R2: In fixed-width mode, a word is rejected with `valid` = 0 if any of these holds: bits 31:28 equal 4'b1111, bit 4 is 1, or bits 27:21 differ from 0001101.
- R3: In fixed-width mode, a matching word with any of bits 19:16 set still decodes fully, and `unpred` = 1. With bits 19:16 all zero, `unpred` = 0.
- R4: With `enc_mode` = 2'b01 (compact), bits 15:8 = 01000110 decode as the high-register move. Its fields are `dst_idx` = {bit 7, bits 2:0} and `src_idx` = bits 6:3. It has `set_flags` = 0, `shift_kind` = 2'b00 and `shift_amt` = 0.
- R5: The high-register move has `unpred` = 1 exactly when `dst_idx` = 15, `in_it` = 1 and `last_in_it` = 0.
- R6: In compact mode, bits 15:13 = 000 together with bits 12:11 other than 11 decode as the shifted move. Its fields are `shift_kind` = bits 12:11, `shift_amt` = bits 10:6, `src_idx` = {0, bits 5:3} and `dst_idx` = {0, bits 2:0}, and `set_flags` = NOT `in_it`. Bits 12:11 = 11 give `valid` = 0.
- R7: The shifted compact move has `unpred` = 1 exactly when bits 12:11 = 00, bits 10:6 = 0 and `in_it` = 1.
- R8: With `enc_mode` = 2'b10 (wide compact), the layout must match in two places: bits 31:21 = 11101010010 and bits 19:16 = 1111. A word that matches decodes as follows:
  - `set_flags` = bit 20;
  - `dst_idx` = bits 11:8;
  - `src_idx` = bits 3:0;
  - `shift_kind` = bits 5:4;
  - `shift_amt` = {bits 14:12, bits 7:6}.
- R9: A valid wide compact word has `unpred` = 1 when `dst_idx` = 15, when `src_idx` = 15, or when bit 15 is set.
- R10: When `valid` = 0, every other output is 0. `enc_mode` = 2'b11 always gives `valid` = 0, and so does any word that matches no form of the selected layout.
- R11: `cond_out` carries bits 31:28 for a valid fixed-width word. For a valid compact or wide compact word it carries 4'b1110 (always execute).
- R12: In compact mode, bits 31:16 of the word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_mode | input | 2 | Layout select: 00 fixed-width, 01 compact, 10 wide compact, 11 none |
| instr_word | input | 32 | Instruction word |
| in_it | input | 1 | Instruction is inside a conditional block |
| last_in_it | input | 1 | Instruction is the last of its conditional block |
| valid | output | 1 | Word is a member of the move-with-shift family |
| unpred | output | 1 | Encoding has an undefined architectural outcome |
| set_flags | output | 1 | Result updates the condition flags |
| cond_out | output | 4 | Condition code for the micro-operation |
| dst_idx | output | 4 | Destination register index |
| src_idx | output | 4 | Source register index |
| shift_kind | output | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR/RRX |
| shift_amt | output | 5 | Raw immediate shift amount |

## Verification
The hardest situations to reach are the ones where `unpred` depends on the conditional-block inputs rather than on the word. For the high-register move, the flag must rise only for a register-15 destination inside a block that is not at its last instruction. For the shifted compact move, the flag must rise only for a zero left shift inside a block. The stimulus table therefore repeats the same compact word under each combination of `in_it` and `last_in_it`, so that a change in the result can come only from those two inputs. The table also places fixed-width words under the wide select, and places non-zero upper bits under the compact select, to show that the layout select alone picks the decoding.

// File: rtl/mvsh_pkg.sv
// Package: shared widths, layout codes and the micro-operation type used by
// every sub-decoder of the move-with-shift decoder.
// Assumes: register indices are 4 bits and shift amounts are 5 bits.
package mvsh_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int REG_W   = 4;
    localparam int KIND_W  = 2;
    localparam int AMT_W   = 5;
    localparam int COND_W  = 4;

    localparam logic [REG_W-1:0]  REG_PC      = '1;
    localparam logic [COND_W-1:0] COND_NEVER  = '1;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1110;
    localparam logic [KIND_W-1:0] KIND_LSL    = 2'b00;
    localparam logic [KIND_W-1:0] KIND_NONE   = 2'b11;

    // Layout select codes.
    typedef enum logic [1:0] {
        ENC_FIXED  = 2'b00,
        ENC_NARROW = 2'b01,
        ENC_WIDE   = 2'b10,
        ENC_OFF    = 2'b11
    } enc_mode_e;

    // Unified micro-operation produced by every layout decoder.
    typedef struct packed {
        logic              valid;
        logic              unpred;
        logic              setflags;
        logic [COND_W-1:0] cond;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic [KIND_W-1:0] kind;
        logic [AMT_W-1:0]  amt;
    } uop_t;

    localparam uop_t UOP_IDLE = '0;

endpackage

// File: rtl/mvsh_fixed_dec.sv
// Module: decodes the 32-bit fixed-width layout of the move-with-shift family.
// Assumes: the full word is presented. Should-be-zero bits that are set are
// tolerated but flagged as undefined.
module mvsh_fixed_dec
    import mvsh_pkg::*;
#(
    parameter logic [6:0] OPC_MATCH = 7'b0001101
) (
    input  logic [WORD_W-1:0] word,
    output uop_t              uo
);

    logic [COND_W-1:0] cond_f;
    logic              opc_hit;
    logic              form_hit;
    logic              sbz_dirty;

    // Purpose: split out the fields that decide whether the word matches.
    always_comb begin
        cond_f    = word[31:28];
        opc_hit   = (word[27:21] == OPC_MATCH);
        sbz_dirty = |word[19:16];
        form_hit  = opc_hit && !word[4] && (cond_f != COND_NEVER);
    end

    // Purpose: build the micro-operation, or all zeros when the word does not match.
    always_comb begin
        uo = UOP_IDLE;
        if (form_hit) begin
            uo.valid    = 1'b1;
            uo.unpred   = sbz_dirty;
            uo.setflags = word[20];
            uo.cond     = cond_f;
            uo.dst      = word[15:12];
            uo.src      = word[3:0];
            uo.kind     = word[6:5];
            uo.amt      = word[11:7];
        end
    end

    // Purpose: a decoded fixed-width op never carries the reserved condition.
    always_comb begin
        if (uo.valid) begin
            AST_FIXED_COND_NOT_RESERVED: assert (uo.cond != COND_NEVER)
                else $error("fixed decode accepted reserved condition"); // R2
        end
    end

endmodule

// File: rtl/mvsh_narrow_dec.sv
// Module: decodes both 16-bit compact forms, the high-register move and the
// shifted low-register move.
// Assumes: the halfword is presented in isolation, and the conditional-block
// inputs describe the position of this instruction.
module mvsh_narrow_dec
    import mvsh_pkg::*;
#(
    parameter logic [7:0] HI_MATCH = 8'b0100_0110,
    parameter logic [2:0] SH_MATCH = 3'b000
) (
    input  logic [HALF_W-1:0] half,
    input  logic              in_it,
    input  logic              last_in_it,
    output uop_t              uo
);

    logic              hi_hit;
    logic              sh_hit;
    logic [REG_W-1:0]  hi_dst;
    logic [KIND_W-1:0] sh_op;
    logic [AMT_W-1:0]  sh_imm;

    // Purpose: recognise the two compact forms and extract their key fields.
    always_comb begin
        hi_hit = (half[15:8] == HI_MATCH);
        sh_op  = half[12:11];
        sh_imm = half[10:6];
        sh_hit = (half[15:13] == SH_MATCH) && (sh_op != KIND_NONE);
        hi_dst = {half[7], half[2:0]};
    end

    // Purpose: build the micro-operation for whichever compact form matched.
    always_comb begin
        uo = UOP_IDLE;
        if (hi_hit) begin
            uo.valid    = 1'b1;
            uo.cond     = COND_ALWAYS;
            uo.dst      = hi_dst;
            uo.src      = half[6:3];
            uo.kind     = KIND_LSL;
            uo.amt      = '0;
            uo.setflags = 1'b0;
            uo.unpred   = (hi_dst == REG_PC) && in_it && !last_in_it;
        end else if (sh_hit) begin
            uo.valid    = 1'b1;
            uo.cond     = COND_ALWAYS;
            uo.dst      = {1'b0, half[2:0]};
            uo.src      = {1'b0, half[5:3]};
            uo.kind     = sh_op;
            uo.amt      = sh_imm;
            uo.setflags = !in_it;
            uo.unpred   = (sh_op == KIND_LSL) && (sh_imm == '0) && in_it;
        end
    end

    // Purpose: check the per-form rules for flags and for undefined outcomes.
    always_comb begin
        if (hi_hit) begin
            AST_HIGHREG_KEEPS_FLAGS: assert (!uo.setflags && uo.amt == '0)
                else $error("high-register move altered flags or shift"); // R4
            AST_HIGHREG_SAFE_OUTSIDE: assert (in_it || !uo.unpred)
                else $error("high-register move undefined outside a block"); // R5
        end
        if (sh_hit && !hi_hit) begin
            AST_SHIFTED_FLAGS_OUTSIDE: assert (uo.setflags != in_it)
                else $error("shifted move flag rule broken"); // R6
            AST_SHIFTED_SAFE_OUTSIDE: assert (in_it || !uo.unpred)
                else $error("shifted move undefined outside a block"); // R7
        end
    end

endmodule

// File: rtl/mvsh_wide_dec.sv
// Module: decodes the 32-bit wide compact layout, with the first halfword in
// bits 31:16.
// Assumes: both halfwords are already joined into one word. Register 15 as
// source or destination is flagged as undefined.
module mvsh_wide_dec
    import mvsh_pkg::*;
#(
    parameter logic [10:0] HEAD_MATCH = 11'b1110_1010_010,
    parameter logic [3:0]  HEAD_TAIL  = 4'b1111
) (
    input  logic [WORD_W-1:0] word,
    output uop_t              uo
);

    logic             head_hit;
    logic [REG_W-1:0] rd_f;
    logic [REG_W-1:0] rm_f;

    // Purpose: match the fixed first halfword and pull out the register fields.
    always_comb begin
        head_hit = (word[31:21] == HEAD_MATCH) && (word[19:16] == HEAD_TAIL);
        rd_f     = word[11:8];
        rm_f     = word[3:0];
    end

    // Purpose: build the micro-operation from the split shift-amount fields.
    always_comb begin
        uo = UOP_IDLE;
        if (head_hit) begin
            uo.valid    = 1'b1;
            uo.cond     = COND_ALWAYS;
            uo.setflags = word[20];
            uo.dst      = rd_f;
            uo.src      = rm_f;
            uo.kind     = word[5:4];
            uo.amt      = {word[14:12], word[7:6]};
            uo.unpred   = (rd_f == REG_PC) || (rm_f == REG_PC) || word[15];
        end
    end

    // Purpose: register 15 at either end of a wide move must be flagged.
    always_comb begin
        if (uo.valid && (uo.dst == REG_PC || uo.src == REG_PC)) begin
            AST_WIDE_PC_FLAGGED: assert (uo.unpred)
                else $error("wide move with register 15 not flagged"); // R9
        end
    end

endmodule

// File: rtl/mvsh_decoder.sv
// Module: top of the move-with-shift decoder. Runs one sub-decoder per layout
// and forwards the result picked by the layout select.
// Assumes: purely combinational use. In compact mode only bits 15:0 are
// meaningful.
module mvsh_decoder
    import mvsh_pkg::*;
(
    input  logic [1:0]  enc_mode,
    input  logic [31:0] instr_word,
    input  logic        in_it,
    input  logic        last_in_it,
    output logic        valid,
    output logic        unpred,
    output logic        set_flags,
    output logic [3:0]  cond_out,
    output logic [3:0]  dst_idx,
    output logic [3:0]  src_idx,
    output logic [1:0]  shift_kind,
    output logic [4:0]  shift_amt
);

    uop_t uo_fixed;
    uop_t uo_narrow;
    uop_t uo_wide;
    uop_t uo_sel;

    mvsh_fixed_dec u_fixed (
        .word (instr_word),
        .uo   (uo_fixed)
    );

    mvsh_narrow_dec u_narrow (
        .half       (instr_word[HALF_W-1:0]),
        .in_it      (in_it),
        .last_in_it (last_in_it),
        .uo         (uo_narrow)
    );

    mvsh_wide_dec u_wide (
        .word (instr_word),
        .uo   (uo_wide)
    );

    // Purpose: pick the micro-operation of the selected layout.
    always_comb begin
        unique case (enc_mode_e'(enc_mode))
            ENC_FIXED:  uo_sel = uo_fixed;
            ENC_NARROW: uo_sel = uo_narrow;
            ENC_WIDE:   uo_sel = uo_wide;
            default:    uo_sel = UOP_IDLE;
        endcase
    end

    // Purpose: drive the flat output ports from the selected micro-operation.
    always_comb begin
        valid      = uo_sel.valid;
        unpred     = uo_sel.unpred;
        set_flags  = uo_sel.setflags;
        cond_out   = uo_sel.cond;
        dst_idx    = uo_sel.dst;
        src_idx    = uo_sel.src;
        shift_kind = uo_sel.kind;
        shift_amt  = uo_sel.amt;
    end

    // Purpose: port-level consistency between the valid flag and the payload.
    always_comb begin
        if (!valid) begin
            AST_IDLE_OUTPUTS_ZERO: assert (!unpred && !set_flags && cond_out == '0
                                           && dst_idx == '0 && src_idx == '0
                                           && shift_kind == '0 && shift_amt == '0)
                else $error("payload present without valid"); // R10
        end
        if (enc_mode == 2'b11) begin
            AST_OFF_MODE_SILENT: assert (!valid)
                else $error("decode produced under the off select"); // R10
        end
        if (valid && enc_mode != 2'b00) begin
            AST_COMPACT_COND_ALWAYS: assert (cond_out == COND_ALWAYS)
                else $error("compact op without always condition"); // R11
        end
    end

endmodule

// File: tb/mvsh_decoder_tb.sv
// Bench: walks a vector table through the decoder, then runs directed checks
// for the idle state and for the upper-bit independence of compact mode.
module mvsh_decoder_tb_top;

    typedef struct packed {
        logic [1:0]  mode;
        logic        it;
        logic        last;
        logic [31:0] word;
        logic        v;
        logic        u;
        logic        f;
        logic [3:0]  c;
        logic [3:0]  d;
        logic [3:0]  s;
        logic [1:0]  k;
        logic [4:0]  a;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 23;

    localparam vec_t VECS [NVEC] = '{
        // R1 fixed LSR #5, flags, cond 0
        '{2'b00, 1'b0, 1'b0, 32'h01B032A7, 1'b1, 1'b0, 1'b1, 4'h0, 4'h3, 4'h7, 2'd1, 5'd5,  8'd1},
        // R11 fixed RRX to r15, cond E passes through
        '{2'b00, 1'b0, 1'b0, 32'hE1A0F062, 1'b1, 1'b0, 1'b0, 4'hE, 4'hF, 4'h2, 2'd3, 5'd0,  8'd11},
        // R3 should-be-zero bits set
        '{2'b00, 1'b0, 1'b0, 32'hA1B51FC4, 1'b1, 1'b1, 1'b1, 4'hA, 4'h1, 4'h4, 2'd2, 5'd31, 8'd3},
        // R2 reserved condition
        '{2'b00, 1'b0, 1'b0, 32'hF1B032A7, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd2},
        // R2 bit 4 set
        '{2'b00, 1'b0, 1'b0, 32'h01B032B7, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd2},
        // R2 opcode mismatch
        '{2'b00, 1'b0, 1'b0, 32'h01D032A7, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd2},
        // R4 high-register move D=1
        '{2'b01, 1'b0, 1'b0, 32'h000046CA, 1'b1, 1'b0, 1'b0, 4'hE, 4'hA, 4'h9, 2'd0, 5'd0,  8'd4},
        // R5 r15 inside block, not last
        '{2'b01, 1'b1, 1'b0, 32'h0000468F, 1'b1, 1'b1, 1'b0, 4'hE, 4'hF, 4'h1, 2'd0, 5'd0,  8'd5},
        // R5 r15 last in block
        '{2'b01, 1'b1, 1'b1, 32'h0000468F, 1'b1, 1'b0, 1'b0, 4'hE, 4'hF, 4'h1, 2'd0, 5'd0,  8'd5},
        // R5 r15 outside block
        '{2'b01, 1'b0, 1'b0, 32'h0000468F, 1'b1, 1'b0, 1'b0, 4'hE, 4'hF, 4'h1, 2'd0, 5'd0,  8'd5},
        // R12 upper bits ignored
        '{2'b01, 1'b0, 1'b0, 32'hDEAD468F, 1'b1, 1'b0, 1'b0, 4'hE, 4'hF, 4'h1, 2'd0, 5'd0,  8'd12},
        // R6 shifted ASR #3 outside block
        '{2'b01, 1'b0, 1'b0, 32'h000010EE, 1'b1, 1'b0, 1'b1, 4'hE, 4'h6, 4'h5, 2'd2, 5'd3,  8'd6},
        // R6 shifted ASR #3 inside block
        '{2'b01, 1'b1, 1'b1, 32'h000010EE, 1'b1, 1'b0, 1'b0, 4'hE, 4'h6, 4'h5, 2'd2, 5'd3,  8'd6},
        // R7 zero LSL inside block
        '{2'b01, 1'b1, 1'b0, 32'h0000001C, 1'b1, 1'b1, 1'b0, 4'hE, 4'h4, 4'h3, 2'd0, 5'd0,  8'd7},
        // R7 zero LSL outside block
        '{2'b01, 1'b0, 1'b0, 32'h0000001C, 1'b1, 1'b0, 1'b1, 4'hE, 4'h4, 4'h3, 2'd0, 5'd0,  8'd7},
        // R6 op 11 rejected
        '{2'b01, 1'b0, 1'b0, 32'h000018EE, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd6},
        // R8 wide LSL #9 with flags
        '{2'b10, 1'b0, 1'b0, 32'hEA5F2344, 1'b1, 1'b0, 1'b1, 4'hE, 4'h3, 4'h4, 2'd0, 5'd9,  8'd8},
        // R9 wide source r15
        '{2'b10, 1'b0, 1'b0, 32'hEA4F75FF, 1'b1, 1'b1, 1'b0, 4'hE, 4'h5, 4'hF, 2'd3, 5'd31, 8'd9},
        // R9 wide destination r15
        '{2'b10, 1'b0, 1'b0, 32'hEA4F0F12, 1'b1, 1'b1, 1'b0, 4'hE, 4'hF, 4'h2, 2'd1, 5'd0,  8'd9},
        // R9 wide bit 15 set
        '{2'b10, 1'b0, 1'b0, 32'hEA5FA344, 1'b1, 1'b1, 1'b1, 4'hE, 4'h3, 4'h4, 2'd0, 5'd9,  8'd9},
        // R8 wide head bits 19:16 not all ones
        '{2'b10, 1'b0, 1'b0, 32'hEA5E2344, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd8},
        // R10 off select
        '{2'b11, 1'b0, 1'b0, 32'h01B032A7, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd10},
        // R10 fixed word under wide select
        '{2'b10, 1'b0, 1'b0, 32'h01B032A7, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 5'd0,  8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  enc_mode = 2'b00;
    logic [31:0] instr_word = '0;
    logic        in_it = 1'b0;
    logic        last_in_it = 1'b0;
    logic        valid, unpred, set_flags;
    logic [3:0]  cond_out, dst_idx, src_idx;
    logic [1:0]  shift_kind;
    logic [4:0]  shift_amt;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    mvsh_decoder dut_i (
        .enc_mode   (enc_mode),
        .instr_word (instr_word),
        .in_it      (in_it),
        .last_in_it (last_in_it),
        .valid      (valid),
        .unpred     (unpred),
        .set_flags  (set_flags),
        .cond_out   (cond_out),
        .dst_idx    (dst_idx),
        .src_idx    (src_idx),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt)
    );

    function automatic logic [21:0] pack_out();
        return {valid, unpred, set_flags, cond_out, dst_idx, src_idx, shift_kind, shift_amt};
    endfunction

    task automatic apply_and_check(input vec_t t);
        logic [21:0] exp_o;
        logic [21:0] got_o;
        @(posedge clk);
        enc_mode   = t.mode;
        instr_word = t.word;
        in_it      = t.it;
        last_in_it = t.last;
        @(negedge clk);
        exp_o = {t.v, t.u, t.f, t.c, t.d, t.s, t.k, t.a};
        got_o = pack_out();
        n_checks++;
        if (got_o !== exp_o) begin
            n_fails++;
            $display("FAIL R%0d word=%h mode=%b it=%b last=%b actual=%h expected=%h",
                     t.req, t.word, t.mode, t.it, t.last, got_o, exp_o);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        vec_t t;
        logic [21:0] ref_o;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R10 idle state: an all-zero fixed word matches nothing.
        @(negedge clk);
        n_checks++;
        if (pack_out() !== '0) begin
            n_fails++;
            $display("FAIL R10 idle actual=%h expected=0", pack_out());
        end

        for (int i = 0; i < NVEC; i++) begin
            apply_and_check(VECS[i]);
        end

        // R12 sweep of upper bits in compact mode against a clean reference.
        t = VECS[11];
        t.word[31:16] = 16'h0000;
        apply_and_check(t);
        ref_o = pack_out();
        for (int j = 0; j < 16; j++) begin
            @(posedge clk);
            instr_word[31:16] = 16'h1 << j;
            @(negedge clk);
            n_checks++;
            if (pack_out() !== ref_o) begin
                n_fails++;
                $display("FAIL R12 upper bit %0d actual=%h expected=%h", j + 16, pack_out(), ref_o);
            end
        end

        // R10 off select with every compact and wide pattern above.
        for (int i = 6; i < 21; i++) begin
            @(posedge clk);
            enc_mode   = 2'b11;
            instr_word = VECS[i].word;
            in_it      = VECS[i].it;
            last_in_it = VECS[i].last;
            @(negedge clk);
            n_checks++;
            if (pack_out() !== '0) begin
                n_fails++;
                $display("FAIL R10 off select vec %0d actual=%h expected=0", i, pack_out());
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule